// File: doc/BRIEF.md
# Composite Clock Violation Decoder

This block sits behind the line receiver of a 64 kbit/s composite timing input. Each bit slot arrives as a one-cycle strobe together with two pulse indications, one for a positive mark and one for a negative mark. The line signal uses alternate mark inversion, and every eighth slot carries a deliberate code-rule violation. A violation is a mark with the same sign as the mark before it. Successive violations alternate in sign. The block finds those violations, locks an 8-slot frame counter to them, and regenerates an 8 kHz clock from that counter.

A second operating mode adds 400 Hz timing. In this mode, one violation position out of every twenty carries an ordinary mark instead of a violation. A second counter locks to these stolen positions and regenerates a 400 Hz clock. The block also raises a flag for every empty slot, and one loss-of-sync flag for each timing level. While a level is out of sync, its regenerated clock keeps running from its own counter. The counter realigns as the level hunts for sync again.

The block runs on a fast system clock. The slot strobe must arrive exactly every `SLOT_CYCLES` system clocks.

Top module: `cc_viol_decoder`

## Requirements
- R1: When `mode_i` is 3'b001, 400 Hz decoding is enabled. Any other code gives 8 kHz-only operation, and in that case `clk400_o` and `sync400_lost_o` stay low.
- R2: A slot with exactly one of `pos_i`/`neg_i` high is a mark; `pos_i` high means a positive mark. A mark is an ordinary mark in two cases: it is the first mark since reset, or its sign differs from the previous mark. Otherwise it is a violation. A violation with the same sign as the previous violation is invalid, and it counts as a miss at an expected frame position.
- R3: A slot with no mark raises `miss_pulse_o` for exactly `SLOT_CYCLES/2` system clocks, starting one clock after its strobe. Both inputs high also counts as no mark. A slot with a mark leaves `miss_pulse_o` low.
- R4: While hunting, a valid violation away from the expected frame position realigns the frame counter, so that slot becomes position 0. The 8 kHz sync is declared after three valid violations in a row at the expected position, and `sync8_lost_o` then falls.
- R5: While in 8 kHz sync, `sync8_lost_o` rises after two consecutive expected positions that do not carry a valid violation. An empty slot elsewhere in the frame does not disturb sync.
- R6: `clk8k_o` is high for the four slots starting at frame position 0 and low for the other four. It keeps this pattern in and out of sync.
- R7: In 400 Hz mode, during 8 kHz sync, an ordinary mark at frame position 0 is a stolen violation. While hunting, a stolen violation away from the expected superframe position realigns the superframe counter. A second stolen violation exactly 20 frames later declares sync, and `sync400_lost_o` falls.
- R8: While in 400 Hz sync, `sync400_lost_o` rises after two consecutive expected superframe positions that do not carry a stolen violation.
- R9: `clk400_o` is high for the ten frames starting at superframe position 0 and low for the next ten.
- R10: After reset, `clk8k_o`, `clk400_o` and `miss_pulse_o` are low and `sync8_lost_o` is high. `sync400_lost_o` is high in 400 Hz mode. Every output settles within three system clocks of a slot strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en_i | input | 1 | One-cycle strobe per 64 kbit/s bit slot |
| pos_i | input | 1 | Positive mark seen in this slot |
| neg_i | input | 1 | Negative mark seen in this slot |
| mode_i | input | 3 | Operating mode code (3'b001 enables 400 Hz decoding) |
| clk8k_o | output | 1 | Regenerated 8 kHz clock |
| clk400_o | output | 1 | Regenerated 400 Hz clock |
| miss_pulse_o | output | 1 | Half-slot pulse for each empty slot |
| sync8_lost_o | output | 1 | High while the 8 kHz timing is out of sync |
| sync400_lost_o | output | 1 | High while the 400 Hz timing is out of sync (400 Hz mode) |

## Verification
A wrong frame phase shows up on `clk8k_o` within one slot, because the output follows the frame counter directly. Each clock is therefore compared against its expected value at the end of every slot. The realign offset is swept over all eight positions, so a hunt that fails to realign, or realigns to the wrong position, shows up as a shifted clock pattern. Acquisition or loss counters that are off by one show up as a sync flag that moves one frame early or late. A sign-tracking error in the mark history turns a valid violation into an invalid one, and that error first shows as delayed 8 kHz acquisition.

// File: rtl/cc_pkg.sv
// Shared types for the composite clock violation decoder.
package cc_pkg;

    // Classification of one bit slot after the sign history is applied.
    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,   // no mark (or both polarities at once)
        CL_PULSE = 2'd1,   // ordinary alternating mark
        CL_VIOL  = 2'd2,   // code-rule violation, sign opposite to the last one
        CL_BADV  = 2'd3    // violation repeating the sign of the last violation
    } slot_cls_t;

    // Mode code that enables the 400 Hz superframe layer.
    localparam logic [2:0] MODE_SUPER = 3'b001;

endpackage

// File: rtl/cc_slot_classify.sv
// Slot classifier. Tracks the sign of the last mark and of the last
// violation, and labels each strobed slot. It also stretches every empty
// slot into a half-slot flag.
// Assumes slot_en_i recurs exactly every SLOT_CYCLES clocks.
module cc_slot_classify
    import cc_pkg::*;
#(
    parameter int SLOT_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      slot_en_i,
    input  logic      pos_i,
    input  logic      neg_i,
    output logic      evt_o,
    output slot_cls_t cls_o,
    output logic      miss_o
);
    localparam int HALF = SLOT_CYCLES / 2;
    localparam int MCW  = $clog2(HALF + 1);

    logic           mark;
    logic           sign;
    slot_cls_t      cls_n;
    logic           have_last_q;
    logic           last_sign_q;
    logic           have_v_q;
    logic           vsign_q;
    logic [MCW-1:0] miss_cnt_q;

    // Decode the raw pulse pair into one mark and its sign.
    always_comb begin
        mark = pos_i ^ neg_i;
        sign = pos_i;
    end

    // Label the current slot from the sign history.
    always_comb begin
        cls_n = CL_NONE;
        if (mark) begin
            if (!have_last_q || (sign != last_sign_q))
                cls_n = CL_PULSE;
            else if (have_v_q && (sign == vsign_q))
                cls_n = CL_BADV;
            else
                cls_n = CL_VIOL;
        end
    end

    // Keep the sign of the previous mark and of the previous violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last_q <= 1'b0;
            last_sign_q <= 1'b0;
            have_v_q    <= 1'b0;
            vsign_q     <= 1'b0;
        end else if (slot_en_i && mark) begin
            have_last_q <= 1'b1;
            last_sign_q <= sign;
            if ((cls_n == CL_VIOL) || (cls_n == CL_BADV)) begin
                have_v_q <= 1'b1;
                vsign_q  <= sign;
            end
        end
    end

    // Register the slot event and its label for the sync stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_o <= 1'b0;
            cls_o <= CL_NONE;
        end else begin
            evt_o <= slot_en_i;
            if (slot_en_i)
                cls_o <= cls_n;
        end
    end

    // Stretch an empty slot into a half-slot flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_cnt_q <= '0;
        else if (slot_en_i && !mark)
            miss_cnt_q <= MCW'(HALF);
        else if (miss_cnt_q != '0)
            miss_cnt_q <= miss_cnt_q - 1'b1;
    end

    assign miss_o = (miss_cnt_q != '0);

endmodule

// File: rtl/cc_phase_lock.sv
// Generic marker lock. A position counter of PERIOD steps advances on each
// tick. While hunting, a hit off position 0 realigns the counter, and ACQ_N
// hits in a row at position 0 declare lock. While locked, LOSS_N
// consecutive position-0 ticks without a hit drop the lock.
// The counter always runs, so the derived clocks keep going out of sync.
module cc_phase_lock #(
    parameter int PERIOD = 8,
    parameter int ACQ_N  = 3,
    parameter int LOSS_N = 2,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic          hit_i,
    output logic [PW-1:0] pos_o,
    output logic          lock_o
);
    localparam int RW = $clog2(ACQ_N + 1);
    localparam int MW = $clog2(LOSS_N + 1);

    logic [PW-1:0] nxt;
    logic [RW-1:0] run_q;
    logic [MW-1:0] miss_q;

    // Position that the coming tick would move to.
    always_comb begin
        nxt = (pos_o == PW'(PERIOD - 1)) ? '0 : pos_o + 1'b1;
    end

    // Hunt, acquire and hold the marker phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pos_o  <= PW'(PERIOD - 1);
            run_q  <= '0;
            miss_q <= '0;
            lock_o <= 1'b0;
        end else if (tick_i) begin
            if (!lock_o) begin
                if (hit_i && (nxt != '0)) begin
                    pos_o <= '0;
                    if (ACQ_N == 1) begin
                        lock_o <= 1'b1;
                        run_q  <= '0;
                    end else begin
                        run_q <= RW'(1);
                    end
                end else begin
                    pos_o <= nxt;
                    if (nxt == '0) begin
                        if (!hit_i) begin
                            run_q <= '0;
                        end else if (run_q == RW'(ACQ_N - 1)) begin
                            lock_o <= 1'b1;
                            run_q  <= '0;
                            miss_q <= '0;
                        end else begin
                            run_q <= run_q + 1'b1;
                        end
                    end
                end
            end else begin
                pos_o <= nxt;
                if (nxt == '0) begin
                    if (hit_i) begin
                        miss_q <= '0;
                    end else if (miss_q == MW'(LOSS_N - 1)) begin
                        lock_o <= 1'b0;
                        miss_q <= '0;
                        run_q  <= '0;
                    end else begin
                        miss_q <= miss_q + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cc_viol_decoder.sv
// Composite clock violation decoder top. Chains the slot classifier, an
// 8-slot frame lock on valid violations, and a 20-frame superframe lock on
// stolen violations. It derives both regenerated clocks from the lock
// counters.
// Assumes the slot strobe period equals SLOT_CYCLES clocks and is at least 4.
module cc_viol_decoder
    import cc_pkg::*;
#(
    parameter int SLOT_CYCLES  = 16,
    parameter int FRAME_SLOTS  = 8,
    parameter int SUPER_FRAMES = 20,
    parameter int ACQ_FRAME    = 3,
    parameter int LOSS_FRAME   = 2,
    parameter int ACQ_SUPER    = 2,
    parameter int LOSS_SUPER   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_en_i,
    input  logic       pos_i,
    input  logic       neg_i,
    input  logic [2:0] mode_i,
    output logic       clk8k_o,
    output logic       clk400_o,
    output logic       miss_pulse_o,
    output logic       sync8_lost_o,
    output logic       sync400_lost_o
);
    localparam int FPW       = $clog2(FRAME_SLOTS);
    localparam int SPW       = $clog2(SUPER_FRAMES);
    localparam int FRAME_HI  = FRAME_SLOTS / 2;
    localparam int SUPER_HI  = SUPER_FRAMES / 2;

    logic           evt_q;
    slot_cls_t      cls_q;
    logic           frame_hit;
    logic [FPW-1:0] frame_pos;
    logic           frame_lock;
    logic           mark_q;
    slot_cls_t      cls_d;
    logic           frame_mark;
    logic           sup_hit;
    logic           mode400;
    logic [SPW-1:0] sup_pos;
    logic           sup_lock;

    cc_slot_classify #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_classify (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en_i (slot_en_i),
        .pos_i     (pos_i),
        .neg_i     (neg_i),
        .evt_o     (evt_q),
        .cls_o     (cls_q),
        .miss_o    (miss_pulse_o)
    );

    // Only valid violations mark the frame.
    assign frame_hit = evt_q && (cls_q == CL_VIOL);

    cc_phase_lock #(
        .PERIOD (FRAME_SLOTS),
        .ACQ_N  (ACQ_FRAME),
        .LOSS_N (LOSS_FRAME)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (1'b0),
        .tick_i (evt_q),
        .hit_i  (frame_hit),
        .pos_o  (frame_pos),
        .lock_o (frame_lock)
    );

    // Delay the slot event and label to line up with the frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
            cls_d  <= CL_NONE;
        end else begin
            mark_q <= evt_q;
            cls_d  <= cls_q;
        end
    end

    assign mode400    = (mode_i == MODE_SUPER);
    assign frame_mark = mark_q && (frame_pos == '0);
    assign sup_hit    = frame_mark && frame_lock && (cls_d == CL_PULSE);

    cc_phase_lock #(
        .PERIOD (SUPER_FRAMES),
        .ACQ_N  (ACQ_SUPER),
        .LOSS_N (LOSS_SUPER)
    ) u_super (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!mode400),
        .tick_i (frame_mark),
        .hit_i  (sup_hit),
        .pos_o  (sup_pos),
        .lock_o (sup_lock)
    );

    // Regenerated clocks and sync flags straight from the lock state.
    assign clk8k_o        = (frame_pos < FPW'(FRAME_HI));
    assign clk400_o       = mode400 && (sup_pos < SPW'(SUPER_HI));
    assign sync8_lost_o   = !frame_lock;
    assign sync400_lost_o = mode400 && !sup_lock;

endmodule

// File: rtl/cc_viol_decoder_chk.sv
// Protocol checker for cc_viol_decoder, bound to every instance.
module cc_viol_decoder_chk
    import cc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       slot_en_i,
    input logic       pos_i,
    input logic       neg_i,
    input logic [2:0] mode_i,
    input logic       clk8k_o,
    input logic       miss_pulse_o,
    input logic       sync8_lost_o,
    input logic       sync400_lost_o,
    input logic       evt_q,
    input slot_cls_t  cls_q,
    input logic       sup_hit
);

    assert_miss_from_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_pulse_o) |-> $past(slot_en_i && (pos_i == neg_i)));

    assert_clk8_moves_on_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk8k_o) |-> $past(evt_q));

    assert_sync8_after_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync8_lost_o) |-> $past(evt_q && (cls_q == CL_VIOL)));

    assert_sync400_after_steal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync400_lost_o) && (mode_i == MODE_SUPER) && ($past(mode_i) == MODE_SUPER))
            |-> $past(sup_hit));

endmodule

bind cc_viol_decoder cc_viol_decoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_en_i      (slot_en_i),
    .pos_i          (pos_i),
    .neg_i          (neg_i),
    .mode_i         (mode_i),
    .clk8k_o        (clk8k_o),
    .miss_pulse_o   (miss_pulse_o),
    .sync8_lost_o   (sync8_lost_o),
    .sync400_lost_o (sync400_lost_o),
    .evt_q          (evt_q),
    .cls_q          (cls_q),
    .sup_hit        (sup_hit)
);

// File: tb/cc_viol_decoder_tb_top.sv
// Bench: sweeps the frame realign offset, then runs a superframe scenario
// and an invalid-violation scenario. It compares every slot against
// arithmetic expectations.
module cc_viol_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 16;
    localparam int HALF       = SLOT / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       slot_en_i;
    logic       pos_i;
    logic       neg_i;
    logic [2:0] mode_i;
    logic       clk8k_o;
    logic       clk400_o;
    logic       miss_pulse_o;
    logic       sync8_lost_o;
    logic       sync400_lost_o;

    int  total = 0;
    int  bad   = 0;
    logic last_pol;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cc_viol_decoder dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_en_i      (slot_en_i),
        .pos_i          (pos_i),
        .neg_i          (neg_i),
        .mode_i         (mode_i),
        .clk8k_o        (clk8k_o),
        .clk400_o       (clk400_o),
        .miss_pulse_o   (miss_pulse_o),
        .sync8_lost_o   (sync8_lost_o),
        .sync400_lost_o (sync400_lost_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Slot kind: 0 ordinary mark, 1 violation (repeat last sign), 2 empty.
    function automatic int kind_of(input int sc, input int off, input int s);
        int r, f;
        if (s < off) return 0;
        r = (s - off) % 8;
        f = (s - off) / 8;
        case (sc)
            0: return (r == 0) ? ((f == 6 || f == 7) ? 2 : 1) : 0;
            1: return (r == 0) ? ((f == 10 || f == 30) ? 0 : 1) : 0;
            default: begin
                if (r == 0) return 1;
                if (r == 7 && (f == 4 || f == 5)) return 2;
                return 0;
            end
        endcase
    endfunction

    function automatic bit lock8_exp(input int sc, input int off, input int s);
        case (sc)
            0: return (s >= off + 16 && s < off + 56) || (s >= off + 80);
            1: return s >= off + 16;
            default: return (s >= off + 16 && s < off + 48) || (s >= off + 72);
        endcase
    endfunction

    task automatic do_reset(input logic [2:0] m);
        mode_i    = m;
        rst_n     = 1'b0;
        slot_en_i = 1'b0;
        pos_i     = 1'b0;
        neg_i     = 1'b0;
        last_pol  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk8k_o == 1'b0, "R10 clk8k after reset", clk8k_o, 0);
        check(clk400_o == 1'b0, "R10 clk400 after reset", clk400_o, 0);
        check(miss_pulse_o == 1'b0, "R10 miss after reset", miss_pulse_o, 0);
        check(sync8_lost_o == 1'b1, "R10 sync8_lost after reset", sync8_lost_o, 1);
        check(sync400_lost_o == (m == 3'b001), "R10 sync400_lost after reset",
              sync400_lost_o, int'(m == 3'b001));
    endtask

    // Drive one slot and count the clocks for which the miss flag is high.
    task automatic run_slot(input int kind, output int hi);
        logic p;
        hi = 0;
        slot_en_i = 1'b1;
        if (kind == 2) begin
            pos_i = 1'b0;
            neg_i = 1'b0;
        end else begin
            p = (kind == 1) ? last_pol : !last_pol;
            pos_i    = p;
            neg_i    = !p;
            last_pol = p;
        end
        for (int i = 0; i < SLOT; i++) begin
            @(negedge clk);
            if (i == 0) begin
                slot_en_i = 1'b0;
                pos_i     = 1'b0;
                neg_i     = 1'b0;
            end
            if (miss_pulse_o) hi++;
        end
    endtask

    task automatic run_scn(input int sc, input int off, input logic [2:0] m, input int n);
        int  hi, k, mk;
        bit  e8, e400, el400;
        do_reset(m);
        for (int s = 0; s < n; s++) begin
            k = kind_of(sc, off, s);
            run_slot(k, hi);
            check(hi == ((k == 2) ? HALF : 0), "R3 miss flag width", hi, (k == 2) ? HALF : 0);
            e8 = (s < off) ? ((s % 8) < 4) : (((s - off) % 8) < 4);
            check(clk8k_o == e8, "R6 clk8k phase", clk8k_o, e8);
            check(sync8_lost_o == !lock8_exp(sc, off, s),
                  (sc == 2) ? "R2 invalid violation sync8" :
                  (sc == 0) ? "R4 R5 sync8 acquire/loss" : "R4 sync8 acquire",
                  sync8_lost_o, int'(!lock8_exp(sc, off, s)));
            if (m == 3'b001) begin
                mk    = s / 8;
                e400  = (mk < 11) ? ((mk % 20) < 10) : (((mk - 11) % 20) < 10);
                el400 = !(mk >= 31 && mk < 71);
                check(clk400_o == e400, "R9 clk400 phase", clk400_o, e400);
                check(sync400_lost_o == el400, "R7 R8 sync400 acquire/loss",
                      sync400_lost_o, el400);
            end else begin
                check(clk400_o == 1'b0 && sync400_lost_o == 1'b0, "R1 400 Hz idle in 8 kHz mode",
                      {clk400_o, sync400_lost_o}, 0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int off = 1; off <= 8; off++)
            run_scn(0, off, (off % 2 == 1) ? 3'b000 : 3'b110, off + 8 * 13);
        run_scn(1, 8, 3'b001, 8 + 8 * 76);
        run_scn(2, 8, 3'b000, 8 + 8 * 12);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule